// File: doc/BRIEF.md
# Programmable Loop Divider with Phase-Frequency Detector

This block sits in the digital part of a frequency synthesizer. It takes one of two VCO edge streams, one for the low band and one for the high band, with the choice set by a latched band bit. It divides the chosen stream by a latched code plus one and compares the divided edges against a reference edge stream in a two-state phase-frequency detector. The detector output drives the controls of an external charge pump: source, sink, and an output enable that is low when the pump should be in high impedance.

All activity runs on one system clock. The VCO and reference signals arrive as single-cycle edge strobes, so the bench can model any VCO frequency by choosing how often it raises the strobe. A divide code written while a division cycle is in progress takes effect only at the next terminal count. This means the cycle that is running is never cut short.

Top module: `loop_div_pfd`

## Requirements
- R1: While reset is low and on the first cycle after it, div_pulse, pump_src, pump_snk and pump_oe are all 0. After reset the divider sits at its terminal count, so the first counted edge raises div_pulse and loads div_code.
- R2: With div_code = N, div_pulse is high for one cycle on every (N+1)-th counted VCO edge. It appears on the cycle after the edge that hits terminal count.
- R3: band_fm = 1 counts only fm_tick and band_fm = 0 counts only am_tick. Edges on the unselected input leave the divider count unchanged.
- R4: A change of div_code during a division cycle does not alter that cycle. The new code governs the following cycle.
- R5: A divided edge that arrives before a reference edge (VCO fast) makes pump_src = 1 and pump_snk = 0 from the second cycle after the counted VCO edge. This state holds until a reference edge arrives.
- R6: A reference edge that arrives before a divided edge (VCO slow) makes pump_snk = 1 and pump_src = 0 from the cycle after ref_tick. This state holds until a divided edge arrives.
- R7: Once both detector states are set, both clear on the next cycle. Edges that arrive together produce no pump_src or pump_snk cycle.
- R8: An edge that arrives in the same cycle as the detector clear is not lost. It sets its own state straight after the clear.
- R9: pump_src and pump_snk are never both 1. pump_oe equals pump_src OR pump_snk.
- R10: The code boundaries divide correctly: N = 0 divides by 1 and N = 2^14-1 divides by 16384.
- R11: Over a run with a VCO above the target frequency, pump_src cycles outnumber pump_snk cycles. Below the target, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| am_tick | input | 1 | Low-band VCO edge strobe |
| fm_tick | input | 1 | High-band VCO edge strobe |
| ref_tick | input | 1 | Reference edge strobe |
| band_fm | input | 1 | Latched band select, 1 = fm_tick, 0 = am_tick |
| div_code | input | 14 | Latched divide code N (ratio N+1) |
| div_pulse | output | 1 | Divided VCO edge, one cycle wide |
| pump_src | output | 1 | Charge pump source request (VCO fast) |
| pump_snk | output | 1 | Charge pump sink request (VCO slow) |
| pump_oe | output | 1 | Pump drive enable, 0 means high impedance |

## Verification
A divided edge and a reference edge can reach the detector in the same cycle. A fresh edge can also arrive in the very cycle the detector is clearing itself. The bench provokes the first case by placing ref_tick one cycle after a counted VCO edge, so both strobes land on the same detector edge. It then checks that pump_oe never rises. For the second case it repeats ref_tick one cycle later and checks that pump_snk is high on the cycle after the clear, so no edge is lost.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

   typedef enum logic [1:0] {
      PUMP_IDLE = 2'b00,
      PUMP_SRC  = 2'b01,
      PUMP_SNK  = 2'b10,
      PUMP_BOTH = 2'b11
   } pump_state_e;

   function automatic pump_state_e pump_decode(input logic fast_set, input logic slow_set);
      pump_state_e s;
      case ({slow_set, fast_set})
         2'b01:   s = PUMP_SRC;
         2'b10:   s = PUMP_SNK;
         2'b11:   s = PUMP_BOTH;
         default: s = PUMP_IDLE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lpd_input_sel.sv
module lpd_input_sel #(
   parameter bit SEL_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic am_tick,
   input  logic fm_tick,
   input  logic band_fm,
   output logic vco_tick
);

   logic chosen;

   always_comb begin
      chosen = band_fm ? fm_tick : am_tick;
   end

   generate
      if (SEL_REG) begin : g_reg
         logic chosen_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chosen_q <= 1'b0;
            else        chosen_q <= chosen;
         end
         assign vco_tick = chosen_q;
      end else begin : g_comb
         assign vco_tick = chosen;
      end
   endgenerate

endmodule

// File: rtl/lpd_divider.sv
module lpd_divider #(
   parameter int CODE_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              term
);

   localparam logic [CODE_W-1:0] CNT_ZERO = '0;

   logic [CODE_W-1:0] cnt;
   logic              at_zero;

   always_comb begin
      at_zero = (cnt == CNT_ZERO);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= CNT_ZERO;
         term <= 1'b0;
      end else begin
         term <= 1'b0;
         if (tick) begin
            if (at_zero) begin
               cnt  <= code;
               term <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assert_term_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      term |-> ($past(tick) && ($past(cnt) == CNT_ZERO)));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_zero) |=> (cnt == $past(code)));

endmodule

// File: rtl/lpd_pfd.sv
module lpd_pfd
   import lpd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        div_ev,
   input  logic        ref_ev,
   output pump_state_e state
);

   logic fast_q;
   logic slow_q;
   logic clr;

   always_comb begin
      clr   = fast_q & slow_q;
      state = pump_decode(fast_q, slow_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fast_q <= 1'b0;
         slow_q <= 1'b0;
      end else if (clr) begin
         fast_q <= div_ev;
         slow_q <= ref_ev;
      end else begin
         fast_q <= fast_q | div_ev;
         slow_q <= slow_q | ref_ev;
      end
   end

   assert_src_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_q && !slow_q && !ref_ev) |=> fast_q);

   assert_snk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_q && !fast_q && !div_ev) |=> slow_q);

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !div_ev && !ref_ev) |=> (!fast_q && !slow_q));

   assert_keep_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ref_ev && !div_ev) |=> (slow_q && !fast_q));

endmodule

// File: rtl/loop_div_pfd.sv
module loop_div_pfd
   import lpd_pkg::*;
#(
   parameter int CODE_W  = 14,
   parameter bit SEL_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              am_tick,
   input  logic              fm_tick,
   input  logic              ref_tick,
   input  logic              band_fm,
   input  logic [CODE_W-1:0] div_code,
   output logic              div_pulse,
   output logic              pump_src,
   output logic              pump_snk,
   output logic              pump_oe
);

   generate
      if (CODE_W < 2 || CODE_W > 24) begin : g_bad_width
         $error("loop_div_pfd: CODE_W must lie in 2..24");
      end
   endgenerate

   logic        vco_tick;
   logic        term;
   pump_state_e pstate;

   lpd_input_sel #(.SEL_REG(SEL_REG)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .am_tick  (am_tick),
      .fm_tick  (fm_tick),
      .band_fm  (band_fm),
      .vco_tick (vco_tick)
   );

   lpd_divider #(.CODE_W(CODE_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (vco_tick),
      .code  (div_code),
      .term  (term)
   );

   lpd_pfd u_pfd (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_ev (term),
      .ref_ev (ref_tick),
      .state  (pstate)
   );

   always_comb begin
      div_pulse = term;
      pump_src  = (pstate == PUMP_SRC);
      pump_snk  = (pstate == PUMP_SNK);
      pump_oe   = pump_src | pump_snk;
   end

endmodule

// File: tb/loop_div_pfd_test.sv
module loop_div_pfd_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        am_tick = 1'b0, fm_tick = 1'b0, ref_tick = 1'b0, band_fm = 1'b1;
   logic [13:0] div_code = 14'd0;
   logic        div_pulse, pump_src, pump_snk, pump_oe;

   int n_cmp = 0, n_bad = 0;
   int pulses = 0, src_cyc = 0, snk_cyc = 0, oe_cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   loop_div_pfd uut (
      .clk(clk), .rst_n(rst_n), .am_tick(am_tick), .fm_tick(fm_tick),
      .ref_tick(ref_tick), .band_fm(band_fm), .div_code(div_code),
      .div_pulse(div_pulse), .pump_src(pump_src), .pump_snk(pump_snk), .pump_oe(pump_oe)
   );

   // monitor: samples outputs at the falling edge and checks R9 every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (div_pulse) pulses++;
         if (pump_src)  src_cyc++;
         if (pump_snk)  snk_cyc++;
         if (pump_oe)   oe_cyc++;
         if ((pump_src && pump_snk) || (pump_oe != (pump_src | pump_snk))) begin
            n_bad++;
            $display("FAIL R9: src=%0b snk=%0b oe=%0b expected exclusive and oe=src|snk",
                     pump_src, pump_snk, pump_oe);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // n consecutive strobes on the fm (fm=1) or am input, then settle
   task automatic ticks(input int n, input bit fm);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (fm) fm_tick = 1'b1; else am_tick = 1'b1;
      end
      @(negedge clk);
      fm_tick = 1'b0; am_tick = 1'b0;
      idle(2);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; fm_tick = 0; am_tick = 0; ref_tick = 0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic t_reset_R1();
      int c;
      rst_n = 1'b0;
      idle(3);
      check({div_pulse, pump_src, pump_snk, pump_oe} == 4'b0, "R1 outputs in reset",
            {div_pulse, pump_src, pump_snk, pump_oe}, 0);
      rst_n = 1'b1;
      idle(1);
      check({div_pulse, pump_src, pump_snk, pump_oe} == 4'b0, "R1 outputs after reset",
            {div_pulse, pump_src, pump_snk, pump_oe}, 0);
      band_fm = 1'b1; div_code = 14'd5;
      c = pulses;
      ticks(1, 1'b1);
      check(pulses - c == 1, "R1 first tick pulses", pulses - c, 1);
   endtask

   task automatic t_ratio_R2();
      int c;
      c = pulses;
      ticks(5, 1'b1);
      check(pulses - c == 0, "R2 five of six ticks", pulses - c, 0);
      ticks(1, 1'b1);
      check(pulses - c == 1, "R2 sixth tick", pulses - c, 1);
      c = pulses;
      ticks(18, 1'b1);
      check(pulses - c == 3, "R2 three periods", pulses - c, 3);
   endtask

   task automatic t_band_R3();
      int c;
      band_fm = 1'b1;
      c = pulses;
      ticks(9, 1'b0);
      check(pulses - c == 0, "R3 am ignored with band_fm=1", pulses - c, 0);
      ticks(5, 1'b1);
      check(pulses - c == 0, "R3 count unchanged by am", pulses - c, 0);
      ticks(1, 1'b1);
      check(pulses - c == 1, "R3 fm counted", pulses - c, 1);
      band_fm = 1'b0;
      c = pulses;
      ticks(9, 1'b1);
      check(pulses - c == 0, "R3 fm ignored with band_fm=0", pulses - c, 0);
      ticks(6, 1'b0);
      check(pulses - c == 1, "R3 am counted", pulses - c, 1);
      band_fm = 1'b1;
   endtask

   task automatic t_reload_R4();
      int c;
      c = pulses;
      ticks(2, 1'b1);
      div_code = 14'd2;
      ticks(3, 1'b1);
      check(pulses - c == 0, "R4 old cycle not shortened", pulses - c, 0);
      ticks(1, 1'b1);
      check(pulses - c == 1, "R4 old cycle ends at six", pulses - c, 1);
      c = pulses;
      ticks(3, 1'b1);
      check(pulses - c == 1, "R4 new code divides by three", pulses - c, 1);
   endtask

   task automatic t_bounds_R10();
      int c;
      div_code = 14'd0;
      ticks(1, 1'b1);
      ticks(2, 1'b1);
      c = pulses;
      ticks(4, 1'b1);
      check(pulses - c == 4, "R10 N=0 divide by one", pulses - c, 4);
      div_code = 14'h3FFF;
      ticks(1, 1'b1);
      c = pulses;
      ticks(16383, 1'b1);
      check(pulses - c == 0, "R10 max code before end", pulses - c, 0);
      ticks(1, 1'b1);
      check(pulses - c == 1, "R10 max code divides by 16384", pulses - c, 1);
   endtask

   // single fm strobe with N=0 at window 0, optional ref strobes at windows
   task automatic t_fast_R5();
      do_reset();
      div_code = 14'd0; band_fm = 1'b1;
      fm_tick = 1'b1;
      @(negedge clk); fm_tick = 1'b0;
      @(negedge clk);
      check(pump_src && !pump_snk && pump_oe, "R5 source when VCO edge first",
            {pump_src, pump_snk}, 1);
      idle(4);
      check(pump_src && !pump_snk, "R5 source held", {pump_src, pump_snk}, 1);
      ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      check(!pump_oe, "R7 both set gives no drive", pump_oe, 0);
      @(negedge clk);
      check(!pump_oe, "R7 cleared after both", pump_oe, 0);
   endtask

   task automatic t_slow_R6();
      do_reset();
      div_code = 14'd0;
      ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      check(pump_snk && !pump_src && pump_oe, "R6 sink when reference first",
            {pump_snk, pump_src}, 2);
      idle(4);
      check(pump_snk && !pump_src, "R6 sink held", {pump_snk, pump_src}, 2);
      fm_tick = 1'b1;
      @(negedge clk); fm_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!pump_oe, "R6 sink ends after divided edge", pump_oe, 0);
   endtask

   task automatic t_coincide_R7();
      int c;
      do_reset();
      c = oe_cyc;
      fm_tick = 1'b1;
      @(negedge clk); fm_tick = 1'b0; ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      idle(4);
      check(oe_cyc - c == 0, "R7 coincident edges no pump", oe_cyc - c, 0);
   endtask

   task automatic t_clear_edge_R8();
      do_reset();
      fm_tick = 1'b1;
      @(negedge clk); fm_tick = 1'b0; ref_tick = 1'b1;
      @(negedge clk);
      @(negedge clk); ref_tick = 1'b0;
      check(pump_snk && !pump_src, "R8 edge in clear cycle kept", {pump_snk, pump_src}, 2);
   endtask

   // VCO model: fm strobe every vco_per cycles, reference every 5 cycles
   task automatic run_loop(input int vco_per, output int s, output int k);
      int s0, k0;
      do_reset();
      div_code = 14'd3;
      s0 = src_cyc; k0 = snk_cyc;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         fm_tick  = ((i % vco_per) == 0);
         ref_tick = ((i % 5) == 0);
      end
      @(negedge clk); fm_tick = 1'b0; ref_tick = 1'b0;
      s = src_cyc - s0; k = snk_cyc - k0;
   endtask

   task automatic t_polarity_R11();
      int s, k;
      run_loop(1, s, k);
      check(s > k, "R11 fast VCO sources", s, k);
      run_loop(2, s, k);
      check(k > s, "R11 slow VCO sinks", k, s);
   endtask

   initial begin
      t_reset_R1();
      t_ratio_R2();
      t_band_R3();
      t_reload_R4();
      t_bounds_R10();
      t_fast_R5();
      t_slow_R6();
      t_coincide_R7();
      t_clear_edge_R8();
      t_polarity_R11();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule